// File: doc/BRIEF.md
# Affine S-Box Regenerator

This block holds a small substitution box in serially shifted truth tables and can rewrite that box in place as an affine image of itself. With the default width the box maps 4-bit inputs to 4-bit outputs. It is stored in two 32-bit tables, and each table supplies two output bits. The lower 16 positions of a table give one output bit, and the upper 16 positions give the other. When the block is idle, a lookup address selects one entry and the nibble appears combinationally on the lookup output.

A start pulse captures a binary matrix A and an offset vector i. The block then replaces every entry S(x) with A·S(x) XOR i, computed over GF(2). There is no second copy of the box. While the tables shift, their read address is held at the last entry, so each old entry reaches the read point in turn, from x = 15 down to x = 0. During the first pass of 16 cycles, the even output bits of each new entry are shifted straight into the tables, and the odd bits are parked in two 16-bit holding registers. During the second pass of 16 cycles, the parked bits are shifted in. The whole rewrite takes 32 clocks. Lookups are meaningful only while busy is low.

Top module: `sbox_affine_regen`

## Requirements
- R1: After reset, a lookup of address x returns nibble x of the parameter BOX_INIT, which is bits [4x+3:4x]. The lookup is combinational from lu_addr_i to lu_data_o while busy_o is low.
- R2: After a rewrite, entry x equals A·S(x) XOR i, where S(x) is the entry before the rewrite. Output bit r is the parity of (matrix_i[4r+3:4r] AND S(x)), XOR index_i[r]. So bit c of row r multiplies input bit c.
- R3: A start_i pulse while idle raises busy_o in the next cycle, and busy_o then stays high for exactly 32 cycles.
- R4: done_o is high for exactly one cycle, the cycle right after busy_o falls. It is low at all other times.
- R5: A start_i pulse while busy_o is high is ignored. It neither restarts nor lengthens the rewrite, and the matrix and offset it carries do not affect the result.
- R6: matrix_i and index_i are captured in the cycle start_i is accepted. Changing them during the rewrite has no effect on the result.
- R7: While idle, the box contents do not change. Lookups repeated at any later time return the same values.
- R8: The identity matrix (matrix_i = 16'h8421) with a zero offset leaves every entry unchanged.
- R9: Back-to-back rewrites compose: each rewrite is applied to the box left by the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, restores BOX_INIT |
| start_i | input | 1 | Request a rewrite (accepted only while idle) |
| matrix_i | input | BITS*BITS | Matrix A, row r in bits [BITS*r+BITS-1:BITS*r] |
| index_i | input | BITS | Offset vector i |
| busy_o | output | 1 | Rewrite in progress; lookups are invalid |
| done_o | output | 1 | One-cycle pulse when the rewrite completes |
| lu_addr_i | input | BITS | Lookup address |
| lu_data_o | output | BITS | Box entry at lu_addr_i |

## Verification
The reset box is read in full. This separates wrong bit-to-table placement and wrong upper/lower half ordering, because every nibble of the default box is distinct. The identity matrix with offset zero must return the box unchanged, which exposes entry reversal or pass swapping. The same matrix with an all-ones offset checks that the offset is applied. A bit-reversal matrix checks that row and column indexing are not transposed. Random invertible matrices with random offsets, applied in a chain, check the full transform and its composition. In one run a competing start is pulsed mid-rewrite, and in every run matrix and offset are scrambled after start. Both checks distinguish latched parameters from live inputs.

// File: rtl/sbox_regen_pkg.sv
package sbox_regen_pkg;

   // Widest box the generic code is meant for; bounds table depth.
   localparam int SBOX_MAX_BITS = 8;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FILL  = 2'd1,   // first pass: even bits into tables, odd bits parked
      PH_DRAIN = 2'd2    // second pass: parked odd bits into tables
   } regen_phase_e;

endpackage

// File: rtl/srl_table.sv
// Serially reconfigurable truth table with two read ports: one on the
// upper half and one on the lower half, sharing one address.
module srl_table #(
   parameter int AW = 4,
   parameter logic [2**(AW+1)-1:0] INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_i,
   input  logic          din_i,
   input  logic [AW-1:0] addr_i,
   output logic          hi_o,
   output logic          lo_o
);
   localparam int DEPTH = 2**(AW+1);

   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cells <= INIT;
      else if (shift_i)
         cells <= {cells[DEPTH-2:0], din_i};
   end

   assign hi_o = cells[{1'b1, addr_i}];
   assign lo_o = cells[{1'b0, addr_i}];

endmodule

// File: rtl/affine_unit.sv
// y = A*s XOR v over GF(2), each row a masked parity.
module affine_unit #(
   parameter int BITS = 4
) (
   input  logic [BITS*BITS-1:0] mtx_i,
   input  logic [BITS-1:0]      vec_i,
   input  logic [BITS-1:0]      s_i,
   output logic [BITS-1:0]      y_o
);
   for (genvar r = 0; r < BITS; r++) begin : g_row
      assign y_o[r] = (^(mtx_i[r*BITS +: BITS] & s_i)) ^ vec_i[r];
   end
endmodule

// File: rtl/regen_ctrl.sv
// Sequencer for the two 2**BITS-cycle passes; captures A and i at start.
module regen_ctrl
   import sbox_regen_pkg::*;
#(
   parameter int BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [BITS*BITS-1:0] matrix_i,
   input  logic [BITS-1:0]      index_i,
   output logic                 busy_o,
   output logic                 fill_o,
   output logic                 done_o,
   output logic [BITS*BITS-1:0] mtx_q_o,
   output logic [BITS-1:0]      idx_q_o
);
   regen_phase_e    phase;
   logic [BITS-1:0] step;
   logic            last_step;

   assign last_step = &step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         step    <= '0;
         done_o  <= 1'b0;
         mtx_q_o <= '0;
         idx_q_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               step <= '0;
               if (start_i) begin
                  phase   <= PH_FILL;
                  mtx_q_o <= matrix_i;
                  idx_q_o <= index_i;
               end
            end
            PH_FILL: begin
               step <= step + 1'b1;
               if (last_step) phase <= PH_DRAIN;
            end
            PH_DRAIN: begin
               step <= step + 1'b1;
               if (last_step) begin
                  phase  <= PH_IDLE;
                  done_o <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy_o = (phase != PH_IDLE);
   assign fill_o = (phase == PH_FILL);

endmodule

// File: rtl/sbox_affine_regen.sv
module sbox_affine_regen #(
   parameter int BITS = 4,
   parameter logic [(2**BITS)*BITS-1:0] BOX_INIT = 64'h8E1C_47B0_D963_5AF2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [BITS*BITS-1:0] matrix_i,
   input  logic [BITS-1:0]      index_i,
   output logic                 busy_o,
   output logic                 done_o,
   input  logic [BITS-1:0]      lu_addr_i,
   output logic [BITS-1:0]      lu_data_o
);
   localparam int ENTRIES = 2**BITS;
   localparam int DEPTH   = 2*ENTRIES;
   localparam int TABLES  = BITS/2;

   if ((BITS % 2) != 0 || BITS < 2 || BITS > sbox_regen_pkg::SBOX_MAX_BITS) begin : g_bad_bits
      $error("sbox_affine_regen: BITS must be even and within 2..8");
   end

   // Table k: upper half holds output bit 2k, lower half holds bit 2k+1.
   function automatic logic [DEPTH-1:0] table_image(input int k);
      logic [DEPTH-1:0] img;
      img = '0;
      for (int x = 0; x < ENTRIES; x++) begin
         img[ENTRIES + x] = BOX_INIT[x*BITS + 2*k];
         img[x]           = BOX_INIT[x*BITS + 2*k + 1];
      end
      return img;
   endfunction

   logic                 busy, fill;
   logic [BITS*BITS-1:0] mtx_q;
   logic [BITS-1:0]      idx_q;
   logic [BITS-1:0]      rd_addr;
   logic [BITS-1:0]      old_entry;
   logic [BITS-1:0]      new_entry;

   regen_ctrl #(.BITS(BITS)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .matrix_i (matrix_i),
      .index_i  (index_i),
      .busy_o   (busy),
      .fill_o   (fill),
      .done_o   (done_o),
      .mtx_q_o  (mtx_q),
      .idx_q_o  (idx_q)
   );

   // During a rewrite the read point is pinned at the last entry.
   assign rd_addr = busy ? '1 : lu_addr_i;

   affine_unit #(.BITS(BITS)) i_affine (
      .mtx_i (mtx_q),
      .vec_i (idx_q),
      .s_i   (old_entry),
      .y_o   (new_entry)
   );

   for (genvar k = 0; k < TABLES; k++) begin : g_tbl
      logic [ENTRIES-1:0] park;
      logic               din;

      always_ff @(posedge clk) begin
         if (!rst_n)
            park <= '0;
         else if (busy)
            park <= {park[ENTRIES-2:0], new_entry[2*k+1]};
      end

      assign din = fill ? new_entry[2*k] : park[ENTRIES-1];

      srl_table #(.AW(BITS), .INIT(table_image(k))) i_table (
         .clk     (clk),
         .rst_n   (rst_n),
         .shift_i (busy),
         .din_i   (din),
         .addr_i  (rd_addr),
         .hi_o    (old_entry[2*k]),
         .lo_o    (old_entry[2*k+1])
      );
   end

   assign busy_o    = busy;
   assign lu_data_o = old_entry;

endmodule

// File: rtl/sbox_affine_regen_chk.sv
module sbox_affine_regen_chk #(
   parameter int BITS = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [BITS-1:0] lu_addr_i,
   input logic [BITS-1:0] lu_data_o
);
   localparam int TOTAL = 2*(2**BITS);

   int run;   // busy cycles already seen in the current rewrite

   always_ff @(posedge clk) begin
      if (!rst_n)      run <= 0;
      else if (busy_o) run <= run + 1;
      else             run <= 0;
   end

   assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // Also covers R5: a restart would push the run past TOTAL.
   assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (run < TOTAL));

   assert_busy_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run == TOTAL));

   assert_done_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_done_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o) && $stable(lu_addr_i)) |-> $stable(lu_data_o));

endmodule

bind sbox_affine_regen sbox_affine_regen_chk #(.BITS(BITS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .lu_addr_i (lu_addr_i),
   .lu_data_o (lu_data_o)
);

// File: tb/test_sbox_affine_regen.sv
module test_sbox_affine_regen;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] BOX0 = 64'h8E1C_47B0_D963_5AF2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] matrix_i = '0;
   logic [3:0]  index_i = '0;
   logic        busy_o, done_o;
   logic [3:0]  lu_addr_i = '0;
   logic [3:0]  lu_data_o;

   int total = 0;
   int failed = 0;
   logic [3:0] mbox [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   sbox_affine_regen i_sbox_affine_regen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .matrix_i(matrix_i),
      .index_i(index_i), .busy_o(busy_o), .done_o(done_o),
      .lu_addr_i(lu_addr_i), .lu_data_o(lu_data_o)
   );

   function automatic logic [3:0] affine(logic [15:0] m, logic [3:0] v, logic [3:0] s);
      logic [3:0] y;
      for (int r = 0; r < 4; r++) y[r] = (^(m[r*4 +: 4] & s)) ^ v[r];
      return y;
   endfunction

   function automatic bit invertible(logic [15:0] m);
      logic [3:0] rows [4];
      logic [3:0] t;
      int rank = 0;
      for (int r = 0; r < 4; r++) rows[r] = m[r*4 +: 4];
      for (int c = 0; c < 4; c++) begin
         int piv = -1;
         for (int r = 3; r >= rank; r--) if (rows[r][c]) piv = r;
         if (piv >= 0) begin
            t = rows[piv]; rows[piv] = rows[rank]; rows[rank] = t;
            for (int r = 0; r < 4; r++)
               if (r != rank && rows[r][c]) rows[r] = rows[r] ^ rows[rank];
            rank++;
         end
      end
      return rank == 4;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_box(string req);
      for (int x = 0; x < 16; x++) begin
         @(negedge clk);
         lu_addr_i = 4'(x);
         #1;
         check(req, 32'(lu_data_o), 32'(mbox[x]), $sformatf("entry %0d", x));
      end
   endtask

   // Runs one rewrite; optionally pokes a competing start mid-way (R5).
   task automatic regen(logic [15:0] m, logic [3:0] v, bit poke, string req);
      int cyc;
      @(negedge clk);
      start_i = 1'b1; matrix_i = m; index_i = v;
      @(negedge clk);
      check("R3", 32'(busy_o), 32'd1, "busy after start");
      start_i = 1'b0;
      matrix_i = ~m; index_i = ~v;            // R6: live inputs must not matter
      cyc = 0;
      while (busy_o) begin
         cyc++;
         @(negedge clk);
         if (poke && cyc == 10) begin
            start_i = 1'b1; matrix_i = 16'h1248; index_i = 4'h5;
         end else begin
            start_i = 1'b0;
         end
      end
      check(poke ? "R5" : "R3", 32'(cyc), 32'd32, "busy length");
      check("R4", 32'(done_o), 32'd1, "done after busy");
      @(negedge clk);
      check("R4", 32'(done_o), 32'd0, "done single cycle");
      for (int x = 0; x < 16; x++) mbox[x] = affine(m, v, mbox[x]);
      check_box(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failed++; total++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      logic [15:0] m;
      void'($urandom(32'd20240611));
      for (int x = 0; x < 16; x++) mbox[x] = BOX0[x*4 +: 4];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(busy_o), 32'd0, "busy at reset");
      check("R1", 32'(done_o), 32'd0, "done at reset");
      check_box("R1");
      repeat (5) @(negedge clk);
      check_box("R7");                       // idle: nothing moved
      regen(16'h8421, 4'h0, 1'b0, "R8");     // identity, zero offset
      regen(16'h8421, 4'hF, 1'b0, "R2");     // offset only
      regen(16'h1248, 4'h3, 1'b0, "R2");     // bit-reversal rows
      regen(16'h8421, 4'hA, 1'b1, "R5");     // competing start ignored
      for (int n = 0; n < 20; n++) begin
         do m = 16'($urandom); while (!invertible(m));
         regen(m, 4'($urandom), 1'b0, (n % 2 == 0) ? "R9" : "R6");
      end
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule